// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins controlled through a simple word-wide register bus. Software writes an output value and a per-pin direction. It can also raise or drop chosen pins atomically through dedicated set and clear words, so no read-modify-write is needed. The block drives `pin_out` and `pin_oe`; the pad drivers and tristate buffers sit outside it. The pin levels enter through a two-flop synchronizer, and software reads the synchronized levels from the input word.

Each pin can raise an interrupt. Three per-pin bit-planes select the trigger condition: detection mode (edge or level), an any-edge select, and a polarity bit. A detected event latches a raw status bit, and software clears that bit by writing ones. The masked status is the raw status gated by the enable and mask planes. The bank's single interrupt line is high while any masked status bit is set.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe` and `bank_irq` are low.
- R2: Offset 0x00 holds the output word, which reads back and drives `pin_out` directly. Offset 0x08 holds the direction word: bit n = 1 makes pin n an output, and `pin_oe` equals this word.
- R3: A write to offset 0x10 drives high every pin whose data bit is 1 and leaves the other pins unchanged. The offset reads zero.
- R4: A write to offset 0x14 drives low every pin whose data bit is 1 and leaves the other pins unchanged. The offset reads zero.
- R5: Offset 0x04 returns the pin levels, bit n for pin n, through two flops. A pin change made before clock edge k shows in reads after edge k+1, and not after edge k.
- R6: Offset 0x34 bit n = 0 selects edge mode. With offset 0x38 bit n = 0, offset 0x3C bit n chooses rising (0) or falling (1). A matching transition of the synchronized pin sets raw status bit n (offset 0x24) one clock after the synchronized level changes. A transition of the other direction does not set it.
- R7: In edge mode with offset 0x38 bit n = 1, either transition sets raw status bit n, whatever the polarity bit holds.
- R8: Offset 0x34 bit n = 1 selects level mode. Polarity 0 sets the status while the synchronized pin is high; polarity 1 sets it while the pin is low. The status is set again every cycle the condition holds, even right after a clear.
- R9: Writing ones to offset 0x30 clears the matching raw status bits. Zero bits leave their bits unchanged, and the offset reads zero.
- R10: If a clear of bit n coincides with a new event on pin n, bit n stays set.
- R11: Raw status latches whatever the enable and mask words hold. Offset 0x28 reads raw AND enable (offset 0x20) AND NOT mask (offset 0x2C).
- R12: `bank_irq` is high exactly when the masked status word is nonzero.
- R13: Writes to read-only offsets (0x04, 0x24, 0x28) and to unused offsets change nothing, and unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Output value for each pin |
| pin_oe | output | NPINS (32) | Output enable for each pin |
| bank_irq | output | 1 | Aggregated bank interrupt |

## Verification
The checker watches a fixed set of behaviours on every cycle:
- the effect of set, clear and direction writes on `pin_out` and `pin_oe`;
- a detected event latching and surviving a simultaneous clear;
- a clear write removing only the bits that have no new event;
- raw status holding still when there is neither event nor clear;
- `bank_irq` staying low while nothing is enabled.

The bench scenarios cover what a per-cycle property cannot pin down: the two-edge input latency, which trigger plane wins for each mode combination, level-mode re-setting after a clear, and the read values of every offset. A cycle-level model in the bench follows random traffic and compares against the design.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets of the register words; software depends on these positions.
  localparam logic [7:0] RG_DOUT  = 8'h00;
  localparam logic [7:0] RG_DIN   = 8'h04;
  localparam logic [7:0] RG_DIR   = 8'h08;
  localparam logic [7:0] RG_DSET  = 8'h10;
  localparam logic [7:0] RG_DCLR  = 8'h14;
  localparam logic [7:0] RG_IEN   = 8'h20;
  localparam logic [7:0] RG_IRAW  = 8'h24;
  localparam logic [7:0] RG_IMSKD = 8'h28;
  localparam logic [7:0] RG_IMASK = 8'h2C;
  localparam logic [7:0] RG_ICLR  = 8'h30;
  localparam logic [7:0] RG_TMODE = 8'h34;
  localparam logic [7:0] RG_TBOTH = 8'h38;
  localparam logic [7:0] RG_TPOL  = 8'h3C;

  // Event condition of one pin from its two latest synchronized samples.
  // mode: 0 edge, 1 level. any_edge: both transitions in edge mode.
  // pol: edge 0 rising / 1 falling; level 0 high / 1 low.
  function automatic logic f_pin_event(input logic now_lvl, input logic old_lvl,
                                       input logic mode, input logic any_edge,
                                       input logic pol);
    logic rise, fall, edge_ev, level_ev;
    rise     = now_lvl & ~old_lvl;
    fall     = ~now_lvl & old_lvl;
    edge_ev  = any_edge ? (rise | fall) : (pol ? fall : rise);
    level_ev = now_lvl ^ pol;
    return mode ? level_ev : edge_ev;
  endfunction

  // Next raw status bit: an event outranks a clear.
  function automatic logic f_status_next(input logic cur, input logic clr,
                                         input logic ev);
    return (cur & ~clr) | ev;
  endfunction

  // Status bit as seen by the interrupt line.
  function automatic logic f_gate(input logic raw, input logic en, input logic msk);
    return raw & en & ~msk;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] mode_lvl,
  input  logic [W-1:0] any_edge,
  input  logic [W-1:0] polarity,
  output logic [W-1:0] evt
);
  logic [W-1:0] lvl_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_old_q <= '0;
    else        lvl_old_q <= lvl_now;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = f_pin_event(lvl_now[i], lvl_old_q[i], mode_lvl[i],
                                any_edge[i], polarity[i]);
  end
endmodule

// File: rtl/gpio_stat_latch.sv
module gpio_stat_latch
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] ena,
  input  logic [W-1:0] msk,
  output logic [W-1:0] raw,
  output logic [W-1:0] gated
);
  logic [W-1:0] raw_q;
  logic [W-1:0] raw_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign raw_d[i] = f_status_next(raw_q[i], clr_bits[i], evt[i]);
    assign gated[i] = f_gate(raw_q[i], ena[i], msk[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             bank_irq
);
  logic [NPINS-1:0] dout_q, dir_q, ien_q, imask_q, tmode_q, tboth_q, tpol_q;
  logic [NPINS-1:0] lvl_w;
  logic [NPINS-1:0] hit_w;
  logic [NPINS-1:0] raw_w;
  logic [NPINS-1:0] masked_w;
  logic [NPINS-1:0] clr_w;
  logic             clr_wr_w;

  assign clr_wr_w = bus_wr && (bus_addr == AW'(RG_ICLR));
  assign clr_w    = clr_wr_w ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      tmode_q <= '0;
      tboth_q <= '0;
      tpol_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(RG_DOUT):  dout_q  <= bus_wdata;
        AW'(RG_DSET):  dout_q  <= dout_q | bus_wdata;
        AW'(RG_DCLR):  dout_q  <= dout_q & ~bus_wdata;
        AW'(RG_DIR):   dir_q   <= bus_wdata;
        AW'(RG_IEN):   ien_q   <= bus_wdata;
        AW'(RG_IMASK): imask_q <= bus_wdata;
        AW'(RG_TMODE): tmode_q <= bus_wdata;
        AW'(RG_TBOTH): tboth_q <= bus_wdata;
        AW'(RG_TPOL):  tpol_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_w)
  );

  gpio_evt_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_now(lvl_w), .mode_lvl(tmode_q),
    .any_edge(tboth_q), .polarity(tpol_q), .evt(hit_w)
  );

  gpio_stat_latch #(.W(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(hit_w), .clr_bits(clr_w),
    .ena(ien_q), .msk(imask_q), .raw(raw_w), .gated(masked_w)
  );

  always_comb begin
    case (bus_addr)
      AW'(RG_DOUT):  bus_rdata = dout_q;
      AW'(RG_DIN):   bus_rdata = lvl_w;
      AW'(RG_DIR):   bus_rdata = dir_q;
      AW'(RG_IEN):   bus_rdata = ien_q;
      AW'(RG_IRAW):  bus_rdata = raw_w;
      AW'(RG_IMSKD): bus_rdata = masked_w;
      AW'(RG_IMASK): bus_rdata = imask_q;
      AW'(RG_TMODE): bus_rdata = tmode_q;
      AW'(RG_TBOTH): bus_rdata = tboth_q;
      AW'(RG_TPOL):  bus_rdata = tpol_q;
      default:       bus_rdata = '0;
    endcase
  end

  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;
  assign bank_irq = |masked_w;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             bank_irq,
  input logic [NPINS-1:0] ev_hit,
  input logic [NPINS-1:0] raw_stat,
  input logic [NPINS-1:0] int_en
);
  logic wr_set, wr_clr, wr_dir, wr_iclr;
  assign wr_set  = bus_wr && (bus_addr == AW'(RG_DSET));
  assign wr_clr  = bus_wr && (bus_addr == AW'(RG_DCLR));
  assign wr_dir  = bus_wr && (bus_addr == AW'(RG_DIR));
  assign wr_iclr = bus_wr && (bus_addr == AW'(RG_ICLR));

  p_set_drives_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata)));

  p_event_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit != '0) |=> ((raw_stat & $past(ev_hit)) == $past(ev_hit)));

  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_iclr |=> ((raw_stat & $past(bus_wdata) & ~$past(ev_hit)) == '0));

  p_raw_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_iclr && ev_hit == '0) |=> (raw_stat == $past(raw_stat)));

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !bank_irq);
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .bank_irq(bank_irq), .ev_hit(hit_w), .raw_stat(raw_w), .int_en(ien_q)
);

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rdata, pout, poe;
  logic        irq;

  int vectors = 0;
  int miss = 0;

  gpio_bank_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .bank_irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] m_out, m_dir, m_en, m_mask, m_meth, m_both, m_pol, m_raw;
  logic [31:0] m_s1, m_cur, m_prev;

  function automatic logic [31:0] m_events(input logic [31:0] c, input logic [31:0] p);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      if (m_meth[i])      e[i] = m_pol[i] ? !c[i] : c[i];
      else if (m_both[i]) e[i] = c[i] != p[i];
      else if (m_pol[i])  e[i] = p[i] && !c[i];
      else                e[i] = !p[i] && c[i];
    end
    return e;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_out;
      8'h04: return m_cur;
      8'h08: return m_dir;
      8'h20: return m_en;
      8'h24: return m_raw;
      8'h28: return m_raw & m_en & ~m_mask;
      8'h2C: return m_mask;
      8'h34: return m_meth;
      8'h38: return m_both;
      8'h3C: return m_pol;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_en = 0; m_mask = 0; m_meth = 0; m_both = 0;
      m_pol = 0; m_raw = 0; m_s1 = 0; m_cur = 0; m_prev = 0;
    end else begin
      logic [31:0] ev;
      ev = m_events(m_cur, m_prev);
      if (wr && addr == 8'h30) m_raw = m_raw & ~wdata;
      m_raw = m_raw | ev;
      m_prev = m_cur; m_cur = m_s1; m_s1 = pins;
      if (wr) begin
        case (addr)
          8'h00: m_out = wdata;
          8'h10: m_out = m_out | wdata;
          8'h14: m_out = m_out & ~wdata;
          8'h08: m_dir = wdata;
          8'h20: m_en = wdata;
          8'h2C: m_mask = wdata;
          8'h34: m_meth = wdata;
          8'h38: m_both = wdata;
          8'h3C: m_pol = wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic look(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); wr = 1'b0; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr = 1'b0; end
  endtask

  task automatic setpins(input logic [31:0] v);
    @(negedge clk); wr = 1'b0; pins = v;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr = 1'b0; pins = '0;
    idle(2);
    rst_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd1234));
    idle(2);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 16; a++) look("R1 reset read", 8'(a*4), 32'h0);
    chk("R1 pin_out", pout, 0);
    chk("R1 pin_oe", poe, 0);
    chk("R1 bank_irq", {31'h0, irq}, 0);

    // R2: output word and direction
    drive(8'h00, 32'hA5A5_0F0F);
    look("R2 output readback", 8'h00, 32'hA5A5_0F0F);
    chk("R2 pin_out", pout, 32'hA5A5_0F0F);
    drive(8'h08, 32'h0000_FFFF);
    look("R2 direction readback", 8'h08, 32'h0000_FFFF);
    chk("R2 pin_oe", poe, 32'h0000_FFFF);

    // R3: atomic set
    drive(8'h10, 32'hF000_0000);
    look("R3 set reads zero", 8'h10, 32'h0);
    chk("R3 pin_out after set", pout, 32'hF5A5_0F0F);

    // R4: atomic clear
    drive(8'h14, 32'h0000_000F);
    look("R4 clear reads zero", 8'h14, 32'h0);
    chk("R4 pin_out after clear", pout, 32'hF5A5_0F00);

    // R5: two-flop input latency
    setpins(32'h1234_5678);
    look("R5 input after one edge", 8'h04, 32'h0);
    look("R5 input after two edges", 8'h04, 32'h1234_5678);

    // R6: rising default latches every rising pin
    idle(2);
    look("R6 rising edges latched", 8'h24, 32'h1234_5678);
    drive(8'h30, 32'hFFFF_FFFF);
    look("R9 full clear", 8'h24, 32'h0);

    // R6: falling on pin 3; pin 4 stays rising-only and must not fire on a fall
    drive(8'h3C, 32'h0000_0008);
    setpins(32'h1234_5660);
    idle(3);
    look("R6 falling selected only", 8'h24, 32'h0000_0008);
    drive(8'h30, 32'hFFFF_FFFF);

    // R7: any-edge on pins 0 and 1; pin 1 polarity says falling but is ignored
    drive(8'h38, 32'h0000_0003);
    drive(8'h3C, 32'h0000_000A);
    setpins(32'h1234_5663);
    idle(3);
    look("R7 both edges rise", 8'h24, 32'h0000_0003);
    drive(8'h30, 32'hFFFF_FFFF);
    setpins(32'h1234_5660);
    idle(3);
    look("R7 both edges fall", 8'h24, 32'h0000_0003);
    drive(8'h30, 32'hFFFF_FFFF);

    // R8: level mode on pin 8
    drive(8'h34, 32'h0000_0100);
    look("R8 level high idle", 8'h24, 32'h0);
    setpins(32'h1234_5760);
    idle(3);
    look("R8 level high latched", 8'h24, 32'h0000_0100);
    drive(8'h30, 32'h0000_0100);
    look("R8 level re-set after clear", 8'h24, 32'h0000_0100);
    drive(8'h3C, 32'h0000_010A);
    drive(8'h30, 32'h0000_0100);
    look("R8 level low inactive while high", 8'h24, 32'h0);
    setpins(32'h1234_5660);
    idle(3);
    look("R8 level low latched", 8'h24, 32'h0000_0100);

    // R10: clear coinciding with an edge
    do_reset();
    setpins(32'h0000_0020);
    idle(1);
    drive(8'h30, 32'h0000_0020);
    look("R10 event beats clear", 8'h24, 32'h0000_0020);

    // R9: zero bits untouched
    setpins(32'h0000_0030);
    idle(3);
    look("R9 two pending", 8'h24, 32'h0000_0030);
    drive(8'h30, 32'h0000_0010);
    look("R9 only selected bit cleared", 8'h24, 32'h0000_0020);
    look("R9 clear word reads zero", 8'h30, 32'h0);

    // R11 / R12: gating and aggregate line
    look("R11 masked with nothing enabled", 8'h28, 32'h0);
    chk("R12 irq idle", {31'h0, irq}, 0);
    drive(8'h20, 32'h0000_0020);
    look("R11 masked when enabled", 8'h28, 32'h0000_0020);
    chk("R12 irq raised", {31'h0, irq}, 1);
    drive(8'h2C, 32'h0000_0020);
    look("R11 masked when masked", 8'h28, 32'h0);
    chk("R12 irq masked off", {31'h0, irq}, 0);
    drive(8'h2C, 32'h0);
    look("R11 unmasked", 8'h28, 32'h0000_0020);
    chk("R12 irq back", {31'h0, irq}, 1);
    drive(8'h30, 32'h0000_0020);
    look("R12 cleared status", 8'h24, 32'h0);
    chk("R12 irq drops after clear", {31'h0, irq}, 0);

    // R13: read-only and unused offsets
    drive(8'h40, 32'hFFFF_FFFF);
    look("R13 unused reads zero", 8'h40, 32'h0);
    drive(8'h0C, 32'hFFFF_FFFF);
    look("R13 gap reads zero", 8'h0C, 32'h0);
    drive(8'h04, 32'hFFFF_FFFF);
    look("R13 input not writable", 8'h04, 32'h0000_0030);
    drive(8'h24, 32'hFFFF_FFFF);
    look("R13 raw not writable", 8'h24, 32'h0);
    drive(8'h28, 32'hFFFF_FFFF);
    look("R13 masked not writable", 8'h28, 32'h0);
    chk("R13 pin_out untouched", pout, 32'h0);
    chk("R13 pin_oe untouched", poe, 32'h0);

    // Random traffic against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0)
        pins = pins ^ ($urandom() & $urandom() & $urandom());
      addr = 8'($urandom_range(0, 16) * 4);
      wr = ($urandom_range(0, 2) == 0);
      wdata = ($urandom_range(0, 1) == 0) ? $urandom() : ($urandom() & $urandom());
      #1;
      chk("R11 random readback", rdata, m_read(addr));
      chk("R2 random pin_out", pout, m_out);
      chk("R2 random pin_oe", poe, m_dir);
      chk("R12 random irq", {31'h0, irq}, {31'h0, |(m_raw & m_en & ~m_mask)});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule